// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status Queue

This block turns an asynchronous serial line into a queue of received characters. It watches the line at a rate set by an oversampling enable and checks each start bit at its middle. It then collects 5 to 8 data bits, least significant bit first, an optional parity bit and a stop bit. Each finished character goes into a small first-in first-out queue. Three flags travel with the character: break, framing error, and a parity flag. The parity flag holds either a parity mismatch or a received address/data bit, depending on the mode.

The consumer sees a ready flag whenever the queue holds a character. The data and the three flags of the oldest character appear on the outputs, and a pop strobe removes that character. One more character can wait in a holding stage behind a full queue. If a further character completes while that stage is occupied, a sticky overrun flag is raised, which only the clear-error input resets. A break produces exactly one queue entry. The receiver then accepts nothing until the line has stayed high for half a bit time.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rx_rdy` and `overrun` are 0.
- R2: `char_len` sets the character length: 0→5, 1→6, 2→7, 3→8 data bits. Bits arrive least significant first, and `rx_data` bits at or above the length read 0.
- R3: With `par_mode`=0 a parity bit follows the data. `par_odd`=0 means even parity and `par_odd`=1 means odd parity. `st_parity` is 1 exactly when the received bit does not match.
- R4: With `par_mode`=1 the parity bit is forced: `st_parity` is 1 when the received parity bit differs from `par_odd`.
- R5: With `par_mode`=3 (multidrop), `st_parity` holds the received address/data bit. With `par_mode`=2 no parity bit is sent and `st_parity` is 0.
- R6: The stop bit is sampled at the centre of the first stop-bit position. If it reads low, `st_frame` is 1.
- R7: A character whose data bits are all zero (and whose parity bit is zero, if present), followed by a low stop sample, is a break: `st_break`=1, `st_frame`=1, `rx_data`=0, and it uses exactly one queue entry. A low level that begins partway through one character first gives that character with a framing error, then a break entry.
- R8: After a break, no entry is created until `rxd` has been high for OSR/2 consecutive oversampling ticks. Shorter high pulses are ignored.
- R9: Characters leave the queue in arrival order. `rx_rdy` is 1 while the queue is not empty. `pop` removes the head, and `pop` on an empty queue has no effect.
- R10: The queue (DEPTH entries) plus the holding stage keep DEPTH+1 characters without loss. A further character sets the sticky `overrun` flag and replaces the waiting one, whose data and status are lost.
- R11: A `clr_err` pulse clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OSR ticks per bit |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 0 parity, 1 forced, 2 none, 3 multidrop |
| par_odd | input | 1 | Odd parity select / forced bit value |
| pop | input | 1 | Remove the head character |
| clr_err | input | 1 | Clear the overrun flag |
| rx_rdy | output | 1 | Queue holds at least one character |
| rx_data | output | 8 | Head character data |
| st_break | output | 1 | Head character is a break |
| st_frame | output | 1 | Head character had a low stop bit |
| st_parity | output | 1 | Parity mismatch or address/data bit of head |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A table of single frames covers each length, each parity mode, both parity senses, good and bad parity bits, and good and low stop bits. These frames separate length masking, parity polarity, forced-bit comparison and the address-bit meaning of the flag. Directed line patterns follow. A long low from the start gives a clean break. A low that begins in the middle of a character must give a framing-error character followed by a break. A short high glitch after a break must not release the receiver. A burst of DEPTH+2 characters must keep the first DEPTH, discard the waiting one, keep the last, and set overrun only on the final character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic [7:0] data;
        logic       brk;
        logic       fe;
        logic       pe;
    } rx_entry_t;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_FORCE  = 2'b01,
        PM_NONE   = 2'b10,
        PM_MDROP  = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK
    } rx_state_e;

    // Right-justify a character that was shifted in from the top.
    function automatic logic [7:0] align_data(logic [7:0] sh, logic [1:0] len);
        return sh >> (2'd3 - len);
    endfunction

    function automatic logic parity_flag(par_mode_e pm, logic odd, logic [7:0] d, logic pb);
        case (pm)
            PM_NORMAL: return (^d) ^ pb ^ odd;
            PM_FORCE:  return pb ^ odd;
            PM_MDROP:  return pb;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic [1:0] char_len,
    input  par_mode_e par_mode,
    input  logic      par_odd,
    output logic      done,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);

    rx_state_e       state;
    logic [CW-1:0]   cnt;
    logic [2:0]      nbit;
    logic [7:0]      sh;
    logic            pbit;
    logic [7:0]      data_al;
    logic            is_brk;

    assign data_al = align_data(sh, char_len);
    assign is_brk  = (data_al == 8'h00) && !rxd &&
                     ((par_mode == PM_NONE) || !pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            nbit  <= '0;
            sh    <= '0;
            pbit  <= 1'b0;
            done  <= 1'b0;
            entry <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: if (!rxd) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                    S_START: if (cnt == HALF) begin
                        cnt   <= '0;
                        nbit  <= '0;
                        state <= rxd ? S_IDLE : S_DATA;
                    end else cnt <= cnt + CW'(1);
                    S_DATA: if (cnt == LAST) begin
                        cnt  <= '0;
                        sh   <= {rxd, sh[7:1]};
                        nbit <= nbit + 3'd1;
                        if (nbit == 3'd4 + {1'b0, char_len})
                            state <= (par_mode == PM_NONE) ? S_STOP : S_PAR;
                    end else cnt <= cnt + CW'(1);
                    S_PAR: if (cnt == LAST) begin
                        cnt   <= '0;
                        pbit  <= rxd;
                        state <= S_STOP;
                    end else cnt <= cnt + CW'(1);
                    S_STOP: if (cnt == LAST) begin
                        cnt        <= '0;
                        done       <= 1'b1;
                        entry.data <= data_al;
                        entry.brk  <= is_brk;
                        entry.fe   <= !rxd;
                        entry.pe   <= parity_flag(par_mode, par_odd, data_al, pbit);
                        state      <= is_brk ? S_BRK : S_IDLE;
                    end else cnt <= cnt + CW'(1);
                    S_BRK: if (rxd) begin
                        if (cnt == HALF) begin
                            cnt   <= '0;
                            state <= S_IDLE;
                        end else cnt <= cnt + CW'(1);
                    end else cnt <= '0;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t din,
    input  logic      pop,
    output rx_entry_t dout,
    output logic      empty,
    output logic      full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            push_ok, pop_ok;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CNTW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= step(wp);
            if (pop_ok)  rp <= step(rp);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic [1:0] char_len,
    input  logic [1:0] par_mode,
    input  logic       par_odd,
    input  logic       pop,
    input  logic       clr_err,
    output logic       rx_rdy,
    output logic [7:0] rx_data,
    output logic       st_break,
    output logic       st_frame,
    output logic       st_parity,
    output logic       overrun
);
    logic      rxd_s;
    logic      char_done;
    rx_entry_t new_ent, hold_ent, head;
    logic      hold_v;
    logic      fifo_full, fifo_empty;
    logic      push;

    rx_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
    );

    rx_framer #(.OSR(OSR)) i_framer (
        .clk(clk), .rst(rst), .tick(os_tick), .rxd(rxd_s),
        .char_len(char_len), .par_mode(par_mode_e'(par_mode)),
        .par_odd(par_odd), .done(char_done), .entry(new_ent)
    );

    assign push = hold_v && !fifo_full;

    // Holding stage: one character may wait behind a full queue.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v   <= 1'b0;
            hold_ent <= '0;
            overrun  <= 1'b0;
        end else begin
            if (char_done) begin
                hold_ent <= new_ent;
                hold_v   <= 1'b1;
            end else if (push) begin
                hold_v <= 1'b0;
            end
            if (char_done && hold_v && fifo_full) overrun <= 1'b1;
            else if (clr_err)                     overrun <= 1'b0;
        end
    end

    rx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk(clk), .rst(rst), .push(push), .din(hold_ent),
        .pop(pop), .dout(head), .empty(fifo_empty), .full(fifo_full)
    );

    assign rx_rdy    = !fifo_empty;
    assign rx_data   = head.data;
    assign st_break  = head.brk;
    assign st_frame  = head.fe;
    assign st_parity = head.pe;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       pop,
    input logic       clr_err,
    input logic       rx_rdy,
    input logic [7:0] rx_data,
    input logic       st_break,
    input logic       st_frame,
    input logic       overrun,
    input logic       char_done,
    input logic       hold_v,
    input logic       fifo_full
);
    a_r10_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(char_done && hold_v && fifo_full));

    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun && !clr_err |=> overrun);

    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        clr_err && !(char_done && hold_v && fifo_full) |=> !overrun);

    a_r9_head_stable: assert property (@(posedge clk) disable iff (rst)
        rx_rdy && !pop |=> rx_rdy && $stable(rx_data));

    a_r9_drain_needs_pop: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_rdy) |-> $past(pop));

    a_r7_break_status: assert property (@(posedge clk) disable iff (rst)
        rx_rdy && st_break |-> st_frame && (rx_data == 8'h00));
endmodule

bind uart_rx_status uart_rx_status_chk i_chk (
    .clk(clk), .rst(rst), .pop(pop), .clr_err(clr_err),
    .rx_rdy(rx_rdy), .rx_data(rx_data), .st_break(st_break),
    .st_frame(st_frame), .overrun(overrun), .char_done(char_done),
    .hold_v(hold_v), .fifo_full(fifo_full)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
    localparam int OSR   = 16;
    localparam int DEPTH = 4;
    localparam int BIT   = OSR;

    typedef struct packed {
        logic [1:0] len;
        logic [1:0] pm;
        logic       ps;
        logic [7:0] data;
        logic       pbit;
        logic       stop;
        logic [7:0] xdata;
        logic       xpe;
        logic       xfe;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 2'd2, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0}, // R2 8 bits
        '{2'd3, 2'd0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0}, // R3 even ok
        '{2'd3, 2'd0, 1'b0, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0}, // R3 even bad
        '{2'd3, 2'd0, 1'b1, 8'hA5, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0}, // R3 odd ok
        '{2'd3, 2'd0, 1'b1, 8'hA5, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b0}, // R3 odd bad
        '{2'd0, 2'd2, 1'b0, 8'hFF, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0}, // R2 5 bits
        '{2'd1, 2'd0, 1'b0, 8'h2C, 1'b1, 1'b1, 8'h2C, 1'b0, 1'b0}, // R3 6 bits
        '{2'd2, 2'd1, 1'b1, 8'h55, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0}, // R4 match
        '{2'd2, 2'd1, 1'b1, 8'h55, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0}, // R4 differ
        '{2'd3, 2'd3, 1'b0, 8'h3C, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b0}, // R5 address
        '{2'd3, 2'd3, 1'b0, 8'h3C, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0}, // R5 data
        '{2'd3, 2'd2, 1'b0, 8'h81, 1'b0, 1'b0, 8'h81, 1'b0, 1'b1}, // R6 low stop
        '{2'd2, 2'd0, 1'b1, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0}, // R7 zero, not break
        '{2'd1, 2'd1, 1'b0, 8'h3F, 1'b0, 1'b0, 8'h3F, 1'b0, 1'b1}  // R6 forced + low stop
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] char_len = 2'd3;
    logic [1:0] par_mode = 2'd2;
    logic       par_odd = 1'b0;
    logic       pop = 1'b0;
    logic       clr_err = 1'b0;
    logic       rx_rdy;
    logic [7:0] rx_data;
    logic       st_break, st_frame, st_parity, overrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_rx_status #(.OSR(OSR), .DEPTH(DEPTH)) i_uart_rx_status (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .char_len(char_len), .par_mode(par_mode), .par_odd(par_odd),
        .pop(pop), .clr_err(clr_err), .rx_rdy(rx_rdy), .rx_data(rx_data),
        .st_break(st_break), .st_frame(st_frame), .st_parity(st_parity),
        .overrun(overrun)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic line(input logic v, input int cycles);
        rxd = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send(input logic [1:0] len, input logic [1:0] pm,
                        input logic [7:0] d, input logic pb, input logic stop);
        line(1'b0, BIT);
        for (int i = 0; i < 5 + int'(len); i++) line(d[i], BIT);
        if (pm != 2'd2) line(pb, BIT);
        if (stop) line(1'b1, BIT);
        else      line(1'b0, 12);
        line(1'b1, 2 * BIT);
    endtask

    task automatic do_pop();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] len, input logic [1:0] pm, input logic ps);
        char_len = len;
        par_mode = pm;
        par_odd  = ps;
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(32'(rx_rdy), 32'd0, "R1 rx_rdy after reset");
        chk(32'(overrun), 32'd0, "R1 overrun after reset");

        // R9: pop on empty queue has no effect
        do_pop();
        chk(32'(rx_rdy), 32'd0, "R9 pop on empty");

        // Vector table
        for (int v = 0; v < NV; v++) begin
            cfg(VEC[v].len, VEC[v].pm, VEC[v].ps);
            send(VEC[v].len, VEC[v].pm, VEC[v].data, VEC[v].pbit, VEC[v].stop);
            chk(32'(rx_rdy), 32'd1, $sformatf("R9 ready vec %0d", v));
            chk(32'(rx_data), 32'(VEC[v].xdata), $sformatf("R2 data vec %0d", v));
            chk(32'(st_parity), 32'(VEC[v].xpe), $sformatf("R3 R4 R5 parity vec %0d", v));
            chk(32'(st_frame), 32'(VEC[v].xfe), $sformatf("R6 frame vec %0d", v));
            chk(32'(st_break), 32'd0, $sformatf("R7 no break vec %0d", v));
            do_pop();
            chk(32'(rx_rdy), 32'd0, $sformatf("R9 drained vec %0d", v));
        end

        // R7: clean break from the start bit
        cfg(2'd3, 2'd2, 1'b0);
        line(1'b0, 12 * BIT);
        line(1'b1, 3 * BIT);
        chk(32'(rx_rdy), 32'd1, "R7 break entry present");
        chk(32'(st_break), 32'd1, "R7 break flag");
        chk(32'(st_frame), 32'd1, "R7 break framing");
        chk(32'(rx_data), 32'd0, "R7 break data");
        do_pop();
        chk(32'(rx_rdy), 32'd0, "R7 break uses one entry");

        // R7: low begins mid-character
        line(1'b0, BIT);
        for (int i = 0; i < 4; i++) line(1'b1, BIT);
        line(1'b0, 30 * BIT);
        line(1'b1, 3 * BIT);
        chk(32'(rx_data), 32'h0F, "R7 mid-char first data");
        chk(32'(st_frame), 32'd1, "R7 mid-char first framing");
        chk(32'(st_break), 32'd0, "R7 mid-char first not break");
        do_pop();
        chk(32'(rx_rdy), 32'd1, "R7 mid-char second present");
        chk(32'(st_break), 32'd1, "R7 mid-char second break");
        do_pop();
        chk(32'(rx_rdy), 32'd0, "R7 mid-char two entries only");

        // R8: short high glitch after break does not re-arm the receiver
        line(1'b0, 12 * BIT);
        line(1'b1, 4);
        line(1'b0, 12 * BIT);
        line(1'b1, 3 * BIT);
        chk(32'(st_break), 32'd1, "R8 first break");
        do_pop();
        chk(32'(rx_rdy), 32'd0, "R8 glitch ignored");
        send(2'd3, 2'd2, 8'h5A, 1'b0, 1'b1);
        chk(32'(rx_data), 32'h5A, "R8 accepts after idle");
        do_pop();

        // R10: overrun
        for (int i = 0; i < DEPTH + 1; i++) send(2'd3, 2'd2, 8'(8'h11 + i), 1'b0, 1'b1);
        chk(32'(overrun), 32'd0, "R10 DEPTH+1 without overrun");
        send(2'd3, 2'd2, 8'(8'h11 + DEPTH + 1), 1'b0, 1'b1);
        chk(32'(overrun), 32'd1, "R10 overrun set");
        for (int i = 0; i < DEPTH; i++) begin
            chk(32'(rx_data), 32'(8'h11 + i), "R10 kept order");
            do_pop();
        end
        chk(32'(rx_data), 32'(8'h11 + DEPTH + 1), "R10 waiting char replaced");
        do_pop();
        chk(32'(rx_rdy), 32'd0, "R10 queue empty");
        chk(32'(overrun), 32'd1, "R10 overrun sticky");

        // R11: clear
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
        @(negedge clk);
        chk(32'(overrun), 32'd0, "R11 overrun cleared");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule